// File: doc/BRIEF.md
# SMBus Host Controller Register Front End

This block holds the software-visible registers of a simple SMBus host controller. A processor reaches them through a 32-bit slave port that addresses whole words and qualifies each write with four byte enables. The registers hold a status byte, a control byte, a target byte (7-bit target address plus a direction bit), a data byte and a command byte. Every other byte lane of the decoded words is plain storage.

Writing a start code into the control byte launches one single-byte transaction. The block takes a snapshot of the target, the direction, the command and the data byte. It offers that snapshot on a valid/ready request port to a downstream bus engine, then waits for a single response pulse. The response says whether any device answered and, on a read, which byte it returned. On completion the block sets a done flag in status. A read that found a responder also replaces the data byte. While a transaction is outstanding, a busy flag is visible and further start codes are ignored.

Top module: `smb_host_regs`

## Requirements
- R1: After reset every register byte reads as zero, the busy and done flags are clear and `req_valid` is low.
- R2: The byte lanes are laid out as follows. Status is word 0 bits 7:0 and control is word 0 bits 23:16. The target is word 1 bits 7:0, with bits 7:1 holding the 7-bit address and bit 0 the direction (1 = read, 0 = write). Data is word 1 bits 23:16 and command is word 2 bits 7:0. Every other lane of words 0 to NUM_WORDS-1 reads back the last byte written to it, and only lanes whose byte enable is set are written.
- R3: A write to the status lane clears each status bit written as 1 and leaves the others unchanged. Bit 4 is the done flag.
- R4: A control-lane write whose byte ANDed with 0x06 equals 0x02, made while idle, raises `req_valid` in the next cycle. The request carries the target, direction, command and data as they stood at launch. The request and its fields stay stable until a cycle with `req_ready` high, after which `req_valid` drops.
- R5: A control-lane write with any other value only stores the byte and launches nothing.
- R6: Status bit 0 reads 1 from the cycle after launch until the cycle after the response. Start codes written in that window store the control byte but launch no further request.
- R7: A `rsp_valid` pulse while awaiting the response ends the transaction and sets status bit 4, whether or not `rsp_present` is high. When the transaction was a read and `rsp_present` is high, `rsp_rdata` replaces the data byte. Otherwise the data byte is unchanged.
- R8: In the cycle of completion, setting the done flag wins over a status write that clears bit 4. The returned read byte wins over a data-lane write.
- R9: A `rsp_valid` pulse with no transaction awaiting a response changes neither status nor data.
- R10: A word address at or above NUM_WORDS reads as zero, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe of the slave port |
| bus_addr | input | ADDR_W | Word address |
| bus_be | input | 4 | Byte enables for the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| req_valid | output | 1 | Transaction request offered |
| req_ready | input | 1 | Downstream accepts the request |
| req_target | output | 7 | Target address of the request |
| req_is_read | output | 1 | Request direction, 1 = read |
| req_cmd | output | 8 | Command byte of the request |
| req_wdata | output | 8 | Data byte sent on a write |
| rsp_valid | input | 1 | Transaction finished (one-cycle pulse) |
| rsp_present | input | 1 | A device answered at the target address |
| rsp_rdata | input | 8 | Byte returned on a read |

## Verification
Transactions are run with random targets, commands and data bytes. They cover both directions and both values of `rsp_present`, so the bench can tell a returned byte apart from a kept data byte. Each run holds `req_ready` low for a random number of cycles, which tests request stability. Some runs also rewrite the source registers and retry the start code mid-flight, which separates the launch snapshot from live register values and shows that busy blocks a second launch. Random lane writes with random byte enables and control values that are not start codes exercise the storage lanes, the write-one-to-clear status and the rule that only the start code launches. Directed cases cover same-cycle completion against status and data writes, stray responses while idle, and out-of-range word addresses.

// File: rtl/smb_pkg.sv
package smb_pkg;

    localparam int unsigned LANES = 4;

    // Word / lane placement of the special bytes
    localparam int unsigned STAT_WORD = 0;
    localparam int unsigned STAT_LANE = 0;
    localparam int unsigned CTRL_WORD = 0;
    localparam int unsigned CTRL_LANE = 2;
    localparam int unsigned TGT_WORD  = 1;
    localparam int unsigned TGT_LANE  = 0;
    localparam int unsigned DATA_WORD = 1;
    localparam int unsigned DATA_LANE = 2;
    localparam int unsigned CMD_WORD  = 2;
    localparam int unsigned CMD_LANE  = 0;

    localparam int unsigned BUSY_BIT = 0;
    localparam int unsigned DONE_BIT = 4;

    localparam logic [7:0] START_MASK = 8'h06;
    localparam logic [7:0] START_CODE = 8'h02;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_REQ  = 2'd1,
        SQ_WAIT = 2'd2
    } sq_state_t;

    typedef struct packed {
        logic [6:0] target;
        logic       is_read;
        logic [7:0] cmd;
        logic [7:0] wdata;
    } smb_req_t;

    function automatic logic is_start_code(input logic [7:0] v);
        return (v & START_MASK) == START_CODE;
    endfunction

    function automatic logic [7:0] lane_of(input logic [31:0] w, input int unsigned lane);
        return w[lane*8 +: 8];
    endfunction

endpackage

// File: rtl/smb_lane_store.sv
module smb_lane_store
    import smb_pkg::*;
#(
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned NUM_WORDS = 4
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [LANES-1:0]                be,
    input  logic [31:0]                     wdata,
    output logic [NUM_WORDS-1:0][31:0]      words_q
);

    logic [NUM_WORDS-1:0] word_sel;

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_sel
        assign word_sel[w] = wr && (addr == ADDR_W'(w));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            words_q <= '0;
        end else begin
            for (int w = 0; w < NUM_WORDS; w++) begin
                for (int l = 0; l < LANES; l++) begin
                    if (word_sel[w] && be[l])
                        words_q[w][l*8 +: 8] <= wdata[l*8 +: 8];
                end
            end
        end
    end

endmodule

// File: rtl/smb_special_regs.sv
module smb_special_regs
    import smb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       stat_wr,
    input  logic [7:0] stat_wval,
    input  logic       data_wr,
    input  logic [7:0] data_wval,
    input  logic       done,
    input  logic       rsp_load,
    input  logic [7:0] rsp_byte,
    output logic [7:0] stat_q,
    output logic [7:0] data_q
);

    logic [7:0] stat_n;

    always_comb begin
        stat_n = stat_q;
        if (stat_wr)
            stat_n = stat_n & ~stat_wval;
        if (done)
            stat_n[DONE_BIT] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            data_q <= '0;
        end else begin
            stat_q <= stat_n;
            if (rsp_load)
                data_q <= rsp_byte;
            else if (data_wr)
                data_q <= data_wval;
        end
    end

endmodule

// File: rtl/smb_seq.sv
module smb_seq
    import smb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  smb_req_t snap,
    input  logic     req_ready,
    input  logic     rsp_valid,
    input  logic     rsp_present,
    output smb_req_t req_q,
    output logic     req_valid,
    output logic     busy,
    output logic     done,
    output logic     rsp_load
);

    sq_state_t state_q, state_n;

    always_comb begin
        state_n = state_q;
        case (state_q)
            SQ_IDLE: if (start)     state_n = SQ_REQ;
            SQ_REQ:  if (req_ready) state_n = SQ_WAIT;
            SQ_WAIT: if (rsp_valid) state_n = SQ_IDLE;
            default:                state_n = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            req_q   <= '0;
        end else begin
            state_q <= state_n;
            if (state_q == SQ_IDLE && start)
                req_q <= snap;
        end
    end

    assign req_valid = (state_q == SQ_REQ);
    assign busy      = (state_q != SQ_IDLE);
    assign done      = (state_q == SQ_WAIT) && rsp_valid;
    assign rsp_load  = done && req_q.is_read && rsp_present;

endmodule

// File: rtl/smb_host_regs.sv
module smb_host_regs
    import smb_pkg::*;
#(
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned NUM_WORDS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [6:0]        req_target,
    output logic              req_is_read,
    output logic [7:0]        req_cmd,
    output logic [7:0]        req_wdata,
    input  logic              rsp_valid,
    input  logic              rsp_present,
    input  logic [7:0]        rsp_rdata
);

    logic [NUM_WORDS-1:0][31:0] words_q;
    logic [7:0] stat_q;
    logic [7:0] data_q;
    logic       busy;
    logic       done;
    logic       rsp_load;
    smb_req_t   snap;
    smb_req_t   req_q;

    // Lane hit decode for the special bytes
    logic stat_wr, data_wr, ctrl_wr, start;
    assign stat_wr = bus_wr && bus_addr == ADDR_W'(STAT_WORD) && bus_be[STAT_LANE];
    assign data_wr = bus_wr && bus_addr == ADDR_W'(DATA_WORD) && bus_be[DATA_LANE];
    assign ctrl_wr = bus_wr && bus_addr == ADDR_W'(CTRL_WORD) && bus_be[CTRL_LANE];
    assign start   = ctrl_wr && is_start_code(lane_of(bus_wdata, CTRL_LANE));

    smb_lane_store #(
        .ADDR_W   (ADDR_W),
        .NUM_WORDS(NUM_WORDS)
    ) store_i (
        .clk    (clk),
        .rst    (rst),
        .wr     (bus_wr),
        .addr   (bus_addr),
        .be     (bus_be),
        .wdata  (bus_wdata),
        .words_q(words_q)
    );

    smb_special_regs special_i (
        .clk      (clk),
        .rst      (rst),
        .stat_wr  (stat_wr),
        .stat_wval(lane_of(bus_wdata, STAT_LANE)),
        .data_wr  (data_wr),
        .data_wval(lane_of(bus_wdata, DATA_LANE)),
        .done     (done),
        .rsp_load (rsp_load),
        .rsp_byte (rsp_rdata),
        .stat_q   (stat_q),
        .data_q   (data_q)
    );

    always_comb begin
        snap.target  = words_q[TGT_WORD][TGT_LANE*8+1 +: 7];
        snap.is_read = words_q[TGT_WORD][TGT_LANE*8];
        snap.cmd     = words_q[CMD_WORD][CMD_LANE*8 +: 8];
        snap.wdata   = data_q;
    end

    smb_seq seq_i (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .snap       (snap),
        .req_ready  (req_ready),
        .rsp_valid  (rsp_valid),
        .rsp_present(rsp_present),
        .req_q      (req_q),
        .req_valid  (req_valid),
        .busy       (busy),
        .done       (done),
        .rsp_load   (rsp_load)
    );

    assign req_target  = req_q.target;
    assign req_is_read = req_q.is_read;
    assign req_cmd     = req_q.cmd;
    assign req_wdata   = req_q.wdata;

    // Read mux with live overlays of status and data
    always_comb begin
        bus_rdata = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (bus_addr == ADDR_W'(w))
                bus_rdata = words_q[w];
        end
        if (bus_addr == ADDR_W'(STAT_WORD)) begin
            bus_rdata[STAT_LANE*8 +: 8]     = stat_q;
            bus_rdata[STAT_LANE*8+BUSY_BIT] = busy;
        end
        if (bus_addr == ADDR_W'(DATA_WORD))
            bus_rdata[DATA_LANE*8 +: 8] = data_q;
    end

endmodule

// File: rtl/smb_host_regs_chk.sv
module smb_host_regs_chk #(
    parameter int unsigned ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [3:0]        bus_be,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              req_valid,
    input logic              req_ready,
    input logic [6:0]        req_target,
    input logic              req_is_read,
    input logic [7:0]        req_cmd,
    input logic [7:0]        req_wdata,
    input logic              rsp_valid,
    input logic              busy,
    input logic              done,
    input logic [7:0]        stat_q
);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready |=> req_valid && $stable(req_target) && $stable(req_is_read)
            && $stable(req_cmd) && $stable(req_wdata)); // R4

    AST_BUSY_SHOWN: assert property (@(posedge clk) disable iff (rst)
        req_valid && bus_addr == '0 |-> bus_rdata[0]); // R6

    AST_NO_RELAUNCH: assert property (@(posedge clk) disable iff (rst)
        busy && !done |=> !$rose(req_valid)); // R6

    AST_DONE_FLAG: assert property (@(posedge clk) disable iff (rst)
        done |=> stat_q[4]); // R7

    AST_STRAY_RSP: assert property (@(posedge clk) disable iff (rst)
        !busy && rsp_valid && !bus_wr |=> $stable(stat_q)); // R9

    AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (rst)
        bus_wr && bus_addr == '0 && bus_be[0] && !done
            |=> stat_q == ($past(stat_q) & ~$past(bus_wdata[7:0]))); // R3

endmodule

bind smb_host_regs smb_host_regs_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_be     (bus_be),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_target (req_target),
    .req_is_read(req_is_read),
    .req_cmd    (req_cmd),
    .req_wdata  (req_wdata),
    .rsp_valid  (rsp_valid),
    .busy       (busy),
    .done       (done),
    .stat_q     (stat_q)
);

// File: tb/smb_host_regs_tb_top.sv
module smb_host_regs_tb_top;

    localparam int ADDR_W = 4;
    localparam int NW     = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [6:0]  req_target;
    logic        req_is_read;
    logic [7:0]  req_cmd;
    logic [7:0]  req_wdata;
    logic        rsp_valid = 1'b0;
    logic        rsp_present = 1'b0;
    logic [7:0]  rsp_rdata = '0;

    always #10 clk = ~clk;

    smb_host_regs #(.ADDR_W(ADDR_W), .NUM_WORDS(NW)) dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .req_valid(req_valid),
        .req_ready(req_ready), .req_target(req_target), .req_is_read(req_is_read),
        .req_cmd(req_cmd), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_present(rsp_present), .rsp_rdata(rsp_rdata)
    );

    int checks = 0;
    int errors = 0;

    // Bench model of the register contents
    logic [31:0] mdl [NW];
    logic [7:0]  mstat = '0;
    logic        mbusy = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input logic [3:0] a);
        logic [31:0] w;
        if (a >= 4'(NW)) return 32'h0;
        w = mdl[a];
        if (a == 4'd0) w[7:0] = mstat | {7'b0, mbusy};
        return w;
    endfunction

    function automatic logic is_start(input logic [7:0] v);
        return (v & 8'h06) == 8'h02;
    endfunction

    task automatic model_write(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
        if (a < 4'(NW)) begin
            for (int l = 0; l < 4; l++) begin
                if (be[l]) begin
                    if (a == 4'd0 && l == 0) mstat = mstat & ~d[7:0];
                    else mdl[a][l*8 +: 8] = d[l*8 +: 8];
                end
            end
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0;
        model_write(a, be, d);
    endtask

    task automatic check_read(input string req, input logic [3:0] a);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp_word(a));
    endtask

    task automatic check_req(input string req, input logic [6:0] t, input logic rd,
                             input logic [7:0] c, input logic [7:0] d);
        chk(req, {req_valid, req_target, req_is_read, req_cmd, req_wdata},
                 {1'b1, t, rd, c, d});
    endtask

    // Program registers, launch, and let the request be accepted.
    task automatic launch(input logic [6:0] t, input logic rd, input logic [7:0] c,
                          input logic [7:0] d, input int dly, input logic meddle);
        logic [7:0] cv;
        bus_write(4'd2, 4'b0001, {24'h0, c});
        bus_write(4'd1, 4'b0101, {8'h00, d, 8'h00, t, rd});
        cv = 8'($urandom) & 8'hF9 | 8'h02;
        bus_write(4'd0, 4'b0100, {8'h00, cv, 16'h0});
        mbusy = 1'b1;
        check_req("R4 launch", t, rd, c, d);
        check_read("R6 busy after launch", 4'd0);
        for (int i = 0; i < dly; i++) @(negedge clk);
        if (meddle) begin
            bus_write(4'd1, 4'b0101, {8'h00, ~d, 8'h00, ~t, ~rd});
            bus_write(4'd0, 4'b0100, {8'h00, 8'h02, 16'h0});
        end
        check_req("R4 request held stable", t, rd, c, d);
        @(negedge clk) req_ready = 1'b1;
        @(negedge clk) req_ready = 1'b0;
        chk("R4 valid drops after accept", {31'h0, req_valid}, 32'h0);
        check_read("R6 busy while awaiting", 4'd0);
        if (meddle) begin
            bus_write(4'd0, 4'b0100, {8'h00, 8'hF2, 16'h0});
            chk("R6 start ignored while busy", {31'h0, req_valid}, 32'h0);
        end
    endtask

    task automatic respond(input logic pres, input logic [7:0] rb, input logic rd);
        @(negedge clk);
        rsp_valid = 1'b1; rsp_present = pres; rsp_rdata = rb;
        @(negedge clk);
        rsp_valid = 1'b0;
        mbusy = 1'b0;
        mstat[4] = 1'b1;
        if (rd && pres) mdl[1][23:16] = rb;
        check_read("R7 status after completion", 4'd0);
        check_read("R7 data after completion", 4'd1);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        for (int w = 0; w < NW; w++) mdl[w] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < NW; a++) check_read("R1 reset value", 4'(a));
        chk("R1 no request after reset", {31'h0, req_valid}, 32'h0);

        // R2 R3 R5 random lane writes
        for (int i = 0; i < 60; i++) begin
            logic [3:0]  a  = 4'($urandom % NW);
            logic [3:0]  be = 4'($urandom);
            logic [31:0] d  = $urandom;
            if (a == 4'd0 && is_start(d[23:16])) d[23:16] = d[23:16] & 8'hF9;
            bus_write(a, be, d);
            check_read("R2 R3 lane readback", a);
            chk("R5 non-start control launches nothing", {31'h0, req_valid}, 32'h0);
        end

        // R3 directed write-one-to-clear on a set done flag
        launch(7'h45, 1'b0, 8'h11, 8'h22, 0, 1'b0);
        respond(1'b1, 8'h99, 1'b0);
        bus_write(4'd0, 4'b0001, 32'h0000_00EF);
        check_read("R3 zero-bit leaves done set", 4'd0);
        bus_write(4'd0, 4'b0001, 32'h0000_0010);
        check_read("R3 one-bit clears done", 4'd0);

        // R4 R6 R7 random transactions
        for (int i = 0; i < 30; i++) begin
            logic [6:0] t  = 7'($urandom);
            logic       rd = 1'($urandom);
            logic [7:0] c  = 8'($urandom);
            logic [7:0] d  = 8'($urandom);
            logic       pr = 1'($urandom);
            logic [7:0] rb = 8'($urandom);
            launch(t, rd, c, d, int'($urandom % 4), (i % 3) == 0);
            respond(pr, rb, rd);
            bus_write(4'd0, 4'b0001, 32'h0000_0010);
            check_read("R3 clear after transaction", 4'd0);
        end

        // R8 completion versus same-cycle status clear
        launch(7'h12, 1'b1, 8'h34, 8'h56, 1, 1'b0);
        @(negedge clk);
        rsp_valid = 1'b1; rsp_present = 1'b1; rsp_rdata = 8'hA5;
        bus_wr = 1'b1; bus_addr = 4'd0; bus_be = 4'b0001; bus_wdata = 32'h0000_00FF;
        @(negedge clk);
        rsp_valid = 1'b0; bus_wr = 1'b0; bus_be = '0;
        mbusy = 1'b0; mstat = 8'h10; mdl[1][23:16] = 8'hA5;
        check_read("R8 done wins over clear", 4'd0);

        // R8 completion versus same-cycle data write
        launch(7'h12, 1'b1, 8'h34, 8'h56, 0, 1'b0);
        @(negedge clk);
        rsp_valid = 1'b1; rsp_present = 1'b1; rsp_rdata = 8'h3C;
        bus_wr = 1'b1; bus_addr = 4'd1; bus_be = 4'b0100; bus_wdata = 32'h00C3_0000;
        @(negedge clk);
        rsp_valid = 1'b0; bus_wr = 1'b0; bus_be = '0;
        mbusy = 1'b0; mdl[1][23:16] = 8'h3C;
        check_read("R8 returned byte wins over data write", 4'd1);

        // R9 stray response while idle
        bus_write(4'd0, 4'b0001, 32'h0000_00FF);
        @(negedge clk);
        rsp_valid = 1'b1; rsp_present = 1'b1; rsp_rdata = 8'h77;
        @(negedge clk);
        rsp_valid = 1'b0;
        check_read("R9 stray response status", 4'd0);
        check_read("R9 stray response data", 4'd1);

        // R10 out-of-range word
        bus_write(4'd9, 4'hF, 32'hDEAD_BEEF);
        check_read("R10 out-of-range reads zero", 4'd9);
        for (int a = 0; a < NW; a++) check_read("R10 no register changed", 4'(a));
        bus_write(4'd9, 4'b0100, 32'h0002_0000);
        chk("R10 out-of-range start ignored", {31'h0, req_valid}, 32'h0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule